// File: doc/BRIEF.md
# Dual-Mode Modular Butterfly

This block is the arithmetic core of a radix-2 number-theoretic transform engine. Each clock it can accept one coefficient pair `(a, b)`, one twiddle `w` and a mode bit. It returns the transformed pair reduced modulo an odd parameter `Q`. A clear mode bit selects the forward (decimation-in-time) butterfly. A set mode bit selects the inverse (decimation-in-frequency) butterfly. Both butterflies share a single pipelined Montgomery multiplier. The mode bit decides where the multiplier sits in the data path:

- In forward mode it sits ahead of the modular add/subtract.
- In inverse mode it sits behind the modular subtract.

Each operand set enters the pipeline tagged with a valid bit and its mode. Results leave after a fixed latency of `LAT` = 5 cycles with their valid and mode tags. Forward and inverse operations may be mixed freely, one per cycle. The twiddle must already be in Montgomery form (`w·2^QW mod Q`), so products come out in the normal domain. Coefficient inputs are assumed to be below `Q`.

Top module: `bfly_unit`

## Requirements
- R1: With `in_inv`=0, `out_x` equals (a + w·b) mod Q, where w is the normal-domain twiddle whose Montgomery form was applied on `in_w`.
- R2: With `in_inv`=0, `out_y` equals (a − w·b) mod Q.
- R3: With `in_inv`=1, `out_x` equals (a + b) mod Q.
- R4: With `in_inv`=1, `out_y` equals ((a − b) mod Q)·w mod Q.
- R5: The result of an operation accepted on a rising edge appears on the outputs after the fifth rising edge counted from and including that edge. `out_valid` is `in_valid` delayed by exactly that many cycles, in both modes.
- R6: A new operand set is accepted on every cycle, with forward and inverse operations mixed in any order, and each one yields its own correct result.
- R7: `out_inv` carries the mode bit of the operation whose result is on the outputs (0 = forward, 1 = inverse).
- R8: Cycles with `in_valid`=0 produce a cycle with `out_valid`=0 in the corresponding output slot.
- R9: A synchronous active-low reset clears `out_valid`. Operations in flight when reset is applied never appear on the outputs.
- R10: Both outputs are always below Q, including for operands at 0 and Q−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set on the inputs is valid this cycle |
| in_inv | input | 1 | Mode: 0 forward butterfly, 1 inverse butterfly |
| in_a | input | QW | First coefficient, below Q |
| in_b | input | QW | Second coefficient, below Q |
| in_w | input | QW | Twiddle in Montgomery form, below Q |
| out_valid | output | 1 | Result on the outputs is valid |
| out_inv | output | 1 | Mode of the result on the outputs |
| out_x | output | QW | First result coefficient |
| out_y | output | QW | Second result coefficient |

## Verification
The pipeline depth is the same in both modes, so every result is due exactly five rising edges after the edge that captures its operands. The bench drives inputs on falling edges. It waits five falling edges before sampling the first result of a burst, and then takes one sample per falling edge. This keeps each output slot aligned with the operand set or bubble that produced it. A dedicated latency check confirms that `out_valid` is still low one cycle before the due slot and high in it. A reset check confirms that operations in flight when reset is applied are never seen on the outputs, over more than a full latency window.

// File: rtl/bfly_pkg.sv
// Package: shared definitions for the modular butterfly.
// Holds the mode encoding and the elaboration-time helper that derives
// the Montgomery constant -Q^-1 mod 2^64 from an odd modulus.
package bfly_pkg;

    typedef enum logic {
        BF_FWD = 1'b0,
        BF_INV = 1'b1
    } bf_mode_e;

    // Newton iteration for the inverse of an odd value modulo 2^64.
    // Seed x = q is correct to 3 bits, and each step doubles the precision.
    function automatic logic [63:0] mont_neg_inv(input logic [63:0] q);
        logic [63:0] x;
        x = q;
        for (int i = 0; i < 6; i++) begin
            x = x * (64'd2 - q * x);
        end
        return 64'd0 - x;
    endfunction

endpackage

// File: rtl/bfly_modaddsub.sv
// Module: combinational modular adder/subtractor.
// Computes (a+b) mod Q and (a-b) mod Q with one conditional correction
// each. Assumes both operands are already below Q.
module bfly_modaddsub #(
    parameter int              QW = 32,
    parameter logic [QW-1:0]   Q  = 32'hFFFF_FFFB
) (
    input  logic [QW-1:0] op_a,
    input  logic [QW-1:0] op_b,
    output logic [QW-1:0] sum,
    output logic [QW-1:0] dif
);
    localparam logic [QW:0] QX = {1'b0, Q};

    logic [QW:0] raw_sum;
    logic [QW:0] raw_dif;

    // Sum with a single subtract-Q correction.
    always_comb begin
        raw_sum = {1'b0, op_a} + {1'b0, op_b};
        if (raw_sum >= QX) sum = QW'(raw_sum - QX);
        else               sum = raw_sum[QW-1:0];
    end

    // Difference with a single add-Q correction on borrow.
    always_comb begin
        raw_dif = {1'b0, op_a} - {1'b0, op_b};
        if (raw_dif[QW]) dif = QW'(raw_dif + QX);
        else             dif = raw_dif[QW-1:0];
    end

endmodule

// File: rtl/bfly_montmul.sv
// Module: three-stage pipelined Montgomery multiplier.
// Produces x*y*2^-QW mod Q exactly MUL_LAT cycles after its inputs are
// sampled. Assumes Q is odd and both inputs are below Q. Accepts a new
// pair every cycle.
module bfly_montmul #(
    parameter int              QW = 32,
    parameter logic [QW-1:0]   Q  = 32'hFFFF_FFFB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [QW-1:0] mx,
    input  logic [QW-1:0] my,
    output logic [QW-1:0] prod
);
    localparam int            PW   = 2 * QW;
    localparam logic [QW-1:0] QINV = QW'(bfly_pkg::mont_neg_inv(64'(Q)));

    logic [PW-1:0] st1_t;
    logic [PW-1:0] st2_t;
    logic [QW-1:0] st2_m;
    logic [QW-1:0] m_next;
    logic [PW:0]   red_sum;
    logic [QW:0]   red_hi;

    // Quotient digit m = t * (-Q^-1) mod 2^QW.
    always_comb begin
        m_next = QW'(st1_t[QW-1:0] * QINV);
    end

    // (t + m*Q) / 2^QW, which lies below 2Q.
    always_comb begin
        red_sum = {1'b0, st2_t} + ((PW+1)'(st2_m) * (PW+1)'(Q));
        red_hi  = red_sum[PW:QW];
    end

    // Stage 1: full product. Stage 2: quotient digit. Stage 3: reduce and correct.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1_t <= '0;
            st2_t <= '0;
            st2_m <= '0;
            prod  <= '0;
        end else begin
            st1_t <= PW'(mx) * PW'(my);
            st2_t <= st1_t;
            st2_m <= m_next;
            if (red_hi >= {1'b0, Q}) prod <= QW'(red_hi - {1'b0, Q});
            else                     prod <= red_hi[QW-1:0];
        end
    end

    // R4/R10: the reduced product never reaches Q.
    a_r10_prod_lt_q: assert property (@(posedge clk) disable iff (!rst_n)
        prod < Q)
        else $error("montmul product out of range");

endmodule

// File: rtl/bfly_unit.sv
// Module: dual-mode modular butterfly (top).
// Stage P: the inverse butterfly does its add/subtract here, and the
// forward butterfly passes its operands through. Stages M1..M3: the shared
// Montgomery multiplier. Stage O: the forward butterfly does its
// add/subtract here, and the inverse butterfly passes its results through.
// Latency LAT = MUL_LAT + 2 in both modes, with an initiation interval of 1.
// Assumes odd Q, inputs below Q, and twiddles in Montgomery form.
module bfly_unit #(
    parameter int              QW = 32,
    parameter logic [QW-1:0]   Q  = 32'hFFFF_FFFB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_inv,
    input  logic [QW-1:0] in_a,
    input  logic [QW-1:0] in_b,
    input  logic [QW-1:0] in_w,
    output logic          out_valid,
    output logic          out_inv,
    output logic [QW-1:0] out_x,
    output logic [QW-1:0] out_y
);
    import bfly_pkg::*;

    localparam int MUL_LAT = 3;
    localparam int LAT     = MUL_LAT + 2;

    logic          p_vld;
    logic          p_inv;
    logic [QW-1:0] p_x0;
    logic [QW-1:0] p_x1;
    logic [QW-1:0] p_w;
    logic [QW-1:0] pre_sum;
    logic [QW-1:0] pre_dif;
    logic [QW-1:0] mul_out;
    logic [QW-1:0] post_sum;
    logic [QW-1:0] post_dif;

    logic          dl_vld [MUL_LAT];
    logic          dl_inv [MUL_LAT];
    logic [QW-1:0] dl_x0  [MUL_LAT];

    bfly_modaddsub #(.QW(QW), .Q(Q)) u_pre (
        .op_a (in_a),
        .op_b (in_b),
        .sum  (pre_sum),
        .dif  (pre_dif)
    );

    // Stage P: the mode picks the raw operands or the inverse add/subtract results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_vld <= 1'b0;
            p_inv <= 1'b0;
            p_x0  <= '0;
            p_x1  <= '0;
            p_w   <= '0;
        end else begin
            p_vld <= in_valid;
            p_inv <= in_inv;
            p_w   <= in_w;
            if (bf_mode_e'(in_inv) == BF_INV) begin
                p_x0 <= pre_sum;
                p_x1 <= pre_dif;
            end else begin
                p_x0 <= in_a;
                p_x1 <= in_b;
            end
        end
    end

    bfly_montmul #(.QW(QW), .Q(Q)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .mx    (p_x1),
        .my    (p_w),
        .prod  (mul_out)
    );

    // Side channel: the unpaired coefficient and the tags follow the multiplier depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MUL_LAT; i++) begin
                dl_vld[i] <= 1'b0;
                dl_inv[i] <= 1'b0;
                dl_x0[i]  <= '0;
            end
        end else begin
            dl_vld[0] <= p_vld;
            dl_inv[0] <= p_inv;
            dl_x0[0]  <= p_x0;
            for (int i = 1; i < MUL_LAT; i++) begin
                dl_vld[i] <= dl_vld[i-1];
                dl_inv[i] <= dl_inv[i-1];
                dl_x0[i]  <= dl_x0[i-1];
            end
        end
    end

    bfly_modaddsub #(.QW(QW), .Q(Q)) u_post (
        .op_a (dl_x0[MUL_LAT-1]),
        .op_b (mul_out),
        .sum  (post_sum),
        .dif  (post_dif)
    );

    // Stage O: the mode picks the forward add/subtract or the inverse pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_inv   <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
        end else begin
            out_valid <= dl_vld[MUL_LAT-1];
            out_inv   <= dl_inv[MUL_LAT-1];
            if (bf_mode_e'(dl_inv[MUL_LAT-1]) == BF_INV) begin
                out_x <= dl_x0[MUL_LAT-1];
                out_y <= mul_out;
            end else begin
                out_x <= post_sum;
                out_y <= post_dif;
            end
        end
    end

    // R5: an accepted operation yields a valid result LAT cycles later.
    a_r5_valid_due: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##LAT out_valid)
        else $error("valid result missing at due slot");

    // R8: a bubble yields an empty output slot.
    a_r8_bubble_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##LAT !out_valid)
        else $error("spurious valid result");

    // R7: the mode tag arrives together with its data.
    a_r7_mode_tag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_inv == $past(in_inv, LAT)))
        else $error("mode tag misaligned");

    // R10: both results are fully reduced.
    a_r10_out_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_x < Q && out_y < Q))
        else $error("result out of range");

    // R3/R4: stage P results are reduced before they reach the multiplier.
    a_r3_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
        p_vld |-> (p_x0 < Q && p_x1 < Q))
        else $error("stage P operand out of range");

endmodule

// File: tb/bfly_unit_tb.sv
// Directed bench for bfly_unit. Each task drives one scenario and checks
// its own results against values computed with 64-bit arithmetic.
module bfly_unit_tb;

    localparam int            QW  = 32;
    localparam logic [31:0]   Q   = 32'hFFFF_FFFB;
    localparam int            LAT = 5;
    localparam int            MAXB = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_inv = 1'b0;
    logic [QW-1:0] in_a = '0;
    logic [QW-1:0] in_b = '0;
    logic [QW-1:0] in_w = '0;
    logic          out_valid;
    logic          out_inv;
    logic [QW-1:0] out_x;
    logic [QW-1:0] out_y;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic          bv   [MAXB];
    logic          binv [MAXB];
    logic [QW-1:0] ba   [MAXB];
    logic [QW-1:0] bb   [MAXB];
    logic [QW-1:0] bw   [MAXB];

    always #5 clk = ~clk;

    bfly_unit #(.QW(QW), .Q(Q)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_inv    (in_inv),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_w      (in_w),
        .out_valid (out_valid),
        .out_inv   (out_inv),
        .out_x     (out_x),
        .out_y     (out_y)
    );

    function automatic logic [63:0] to_mont(input logic [63:0] w);
        return (w << 32) % {32'd0, Q};
    endfunction

    // Expected pair for normal-domain twiddle w.
    function automatic void expect_pair(input logic inv, input logic [63:0] a,
                                        input logic [63:0] b, input logic [63:0] w,
                                        output logic [63:0] ex, output logic [63:0] ey);
        logic [63:0] q, p, d;
        q = {32'd0, Q};
        if (!inv) begin
            p  = (w * b) % q;
            ex = (a + p) % q;
            ey = (a + q - p) % q;
        end else begin
            d  = (a + q - b) % q;
            ex = (a + b) % q;
            ey = (d * w) % q;
        end
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Slot i holds normal-domain twiddle wn; the Montgomery form is applied on in_w.
    task automatic set_slot(input int i, input logic v, input logic inv,
                            input logic [31:0] a, input logic [31:0] b, input logic [31:0] wn);
        bv[i] = v; binv[i] = inv; ba[i] = a; bb[i] = b; bw[i] = wn;
    endtask

    // Drives n slots back to back and checks every output slot (R1-R4, R6, R7, R8).
    task automatic run_burst(input int n, input string tag);
        @(negedge clk);
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    in_valid = bv[i];
                    in_inv   = binv[i];
                    in_a     = ba[i];
                    in_b     = bb[i];
                    in_w     = to_mont({32'd0, bw[i]})[31:0];
                    @(negedge clk);
                end
                in_valid = 1'b0;
            end
            begin
                repeat (LAT) @(negedge clk);
                for (int i = 0; i < n; i++) begin
                    logic [63:0] ex, ey;
                    if (bv[i]) begin
                        expect_pair(binv[i], {32'd0, ba[i]}, {32'd0, bb[i]}, {32'd0, bw[i]}, ex, ey);
                        check({tag, " R5 valid"}, {63'd0, out_valid}, 64'd1);
                        check({tag, " R7 mode"}, {63'd0, out_inv}, {63'd0, binv[i]});
                        if (!binv[i]) begin
                            check({tag, " R1 fwd x"}, {32'd0, out_x}, ex);
                            check({tag, " R2 fwd y"}, {32'd0, out_y}, ey);
                        end else begin
                            check({tag, " R3 inv x"}, {32'd0, out_x}, ex);
                            check({tag, " R4 inv y"}, {32'd0, out_y}, ey);
                        end
                    end else begin
                        check({tag, " R8 bubble"}, {63'd0, out_valid}, 64'd0);
                    end
                    @(negedge clk);
                end
            end
        join
    endtask

    task automatic t_reset_state();
        check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_forward();
        set_slot(0, 1, 0, 32'd5, 32'd7, 32'd3);
        set_slot(1, 1, 0, 32'd1, 32'd2, 32'd0);
        set_slot(2, 1, 0, 32'hFFFF_FFFA, 32'hFFFF_FFFA, 32'hFFFF_FFFA);
        set_slot(3, 1, 0, 32'd0, 32'd1, 32'd1);
        set_slot(4, 1, 0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F);
        run_burst(5, "forward");
    endtask

    task automatic t_inverse();
        set_slot(0, 1, 1, 32'd5, 32'd7, 32'd3);
        set_slot(1, 1, 1, 32'd9, 32'd2, 32'd1);
        set_slot(2, 1, 1, 32'hFFFF_FFFA, 32'hFFFF_FFFA, 32'hFFFF_FFFA);
        set_slot(3, 1, 1, 32'd0, 32'hFFFF_FFFA, 32'h8000_0001);
        set_slot(4, 1, 1, 32'hDEAD_BEEF, 32'h0000_0001, 32'h7777_1234);
        run_burst(5, "inverse");
    endtask

    // R10: results at the top of the range stay reduced.
    task automatic t_range();
        set_slot(0, 1, 0, 32'hFFFF_FFFA, 32'd1, 32'd1);
        set_slot(1, 1, 1, 32'hFFFF_FFFA, 32'd1, 32'd2);
        run_burst(2, "range");
        check("R10 x below Q", {63'd0, (out_x < Q)}, 64'd1);
        check("R10 y below Q", {63'd0, (out_y < Q)}, 64'd1);
    endtask

    // R6/R7/R8: mixed modes every cycle with bubbles.
    task automatic t_mixed();
        for (int i = 0; i < 12; i++) begin
            set_slot(i, (i % 5) != 3, i[0],
                     32'h1000_0007 * (i + 1), 32'hF00D_0003 + 32'(i * 977),
                     32'h0102_0305 * (i + 3));
        end
        run_burst(12, "mixed");
    endtask

    // R5: exact due slot for a single operation.
    task automatic t_latency();
        logic [63:0] ex, ey;
        @(negedge clk);
        in_valid = 1'b1; in_inv = 1'b0;
        in_a = 32'd100; in_b = 32'd3; in_w = to_mont(64'd4)[31:0];
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 2) @(negedge clk);
        check("R5 early slot empty", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check("R5 due slot valid", {63'd0, out_valid}, 64'd1);
        expect_pair(1'b0, 64'd100, 64'd3, 64'd4, ex, ey);
        check("R5 R1 value", {32'd0, out_x}, ex);
        @(negedge clk);
        check("R5 one-shot", {63'd0, out_valid}, 64'd0);
    endtask

    // R9: operations in flight at reset never reach the outputs.
    task automatic t_reset_flush();
        @(negedge clk);
        in_valid = 1'b1; in_inv = 1'b1; in_a = 32'd11; in_b = 32'd4;
        in_w = to_mont(64'd2)[31:0];
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LAT + 2; i++) begin
            check("R9 flushed", {63'd0, out_valid}, 64'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(10 * 20000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_forward();
        t_inverse();
        t_range();
        t_mixed();
        t_latency();
        t_reset_flush();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule